// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This combinational block forms the fetch stage of a small 64-bit teaching processor. Each cycle it receives a ten-byte window of instruction memory that starts at the current program counter, together with a flag that marks the fetch address as bad. From these it extracts the opcode and function nibbles, the two register specifiers and the 64-bit constant. It also returns the address of the next sequential instruction, a flag that says whether the opcode is defined, and a status code.

The opcode alone determines the instruction's length. A register-specifier byte may follow the first byte, and an eight-byte constant may follow that. The splitter aligns the constant to whichever of these is present. A bad fetch address turns the instruction into a no-op, so that nothing downstream acts on garbage bytes. The surrounding pipeline uses the outputs directly for decode and for sequential PC selection.

Top module: `fetch_split`

## Requirements
- R1: With no fetch error, `icode` equals bits [7:4] of window byte 0 (the byte at `pc`, window bits [7:0]) and `ifun` equals bits [3:0] of that byte.
- R2: For opcodes 2 (cmov), 3 (irmov), 4 (rmmov), 5 (mrmov), 6 (op), 0xA (push) and 0xB (pop), a register byte is present at window byte 1. `rA` is its upper nibble and `rB` its lower nibble.
- R3: `valC` is eight window bytes in little-endian order. It starts at window byte 2 when a register byte is present and at byte 1 otherwise. This applies to every opcode.
- R4: `valP` equals `pc` + 1, plus 1 if a register byte is present, plus 8 if a constant is present. Opcodes 3, 4, 5, 7 (jump) and 8 (call) carry a constant. So the length is 2 for op/cmov/push/pop, 10 for irmov/rmmov/mrmov, 9 for jump/call and 1 for halt, nop, ret and undefined opcodes.
- R5: When no register byte is present, `rA` and `rB` are both 0xF.
- R6: When `memErr` is 1, `icode` is 1 and `ifun` is 0, whatever the window holds. The instruction is then treated as a one-byte no-op: `valP` = `pc`+1 and `rA` = `rB` = 0xF.
- R7: `instrValid` is 1 exactly when the resulting `icode` is 0x0 to 0xB. Opcodes 0xC to 0xF are undefined and get the length 1.
- R8: `stat` uses the encoding AOK=1, HLT=2, ADR=3, INS=4. It is HLT for opcode 0, INS for an undefined opcode and AOK otherwise.
- R9: `memErr` takes priority: it gives `stat`=ADR even when byte 0 holds a halt or an undefined opcode.
- R10: `valP` is computed modulo 2^64, so a `pc` near the top of the address space wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 64 | Address of window byte 0 |
| memWindow | input | 80 | Ten instruction bytes; byte i at bits [8i+7:8i] |
| memErr | input | 1 | Fetch address invalid |
| icode | output | 4 | Opcode nibble (no-op on error) |
| ifun | output | 4 | Function nibble |
| rA | output | 4 | First register specifier or 0xF |
| rB | output | 4 | Second register specifier or 0xF |
| valC | output | 64 | Aligned little-endian constant |
| valP | output | 64 | Address of the next sequential instruction |
| instrValid | output | 1 | Opcode is defined |
| stat | output | 3 | Fetch status code |

## Verification
The block holds no state, so any fault in the length or alignment logic shows up at the ports in the same cycle as the window that triggers it. The visible symptoms are a `valP` offset other than 1, 2, 9 or 10, a constant shifted by one byte, or register specifiers taken from a constant byte. A wrong choice of strobes for a single opcode shows up only when that opcode is presented. For this reason the stimulus covers all sixteen opcode values, runs the error flag against halt, undefined and normal bytes, and wraps the address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam logic [3:0] IC_HALT  = 4'h0;
  localparam logic [3:0] IC_NOP   = 4'h1;
  localparam logic [3:0] IC_CMOV  = 4'h2;
  localparam logic [3:0] IC_IRMOV = 4'h3;
  localparam logic [3:0] IC_RMMOV = 4'h4;
  localparam logic [3:0] IC_MRMOV = 4'h5;
  localparam logic [3:0] IC_OP    = 4'h6;
  localparam logic [3:0] IC_JUMP  = 4'h7;
  localparam logic [3:0] IC_CALL  = 4'h8;
  localparam logic [3:0] IC_RET   = 4'h9;
  localparam logic [3:0] IC_PUSH  = 4'hA;
  localparam logic [3:0] IC_POP   = 4'hB;
  localparam logic [3:0] REG_NONE = 4'hF;

  typedef enum logic [2:0] {
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } fetchStat_e;

  typedef struct packed {
    logic hasRegByte;
    logic hasConst;
  } fetchStrobes_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic [7:0]    opByte,
  input  logic          memErr,
  output logic [3:0]    icode,
  output logic [3:0]    ifun,
  output logic          instrValid,
  output logic [2:0]    stat,
  output fetchStrobes_t strobes
);
  logic [3:0] rawCode;

  always_comb begin
    rawCode = opByte[7:4];
    if (memErr) begin
      icode = IC_NOP;
      ifun  = 4'h0;
    end else begin
      icode = rawCode;
      ifun  = opByte[3:0];
    end
  end

  always_comb begin
    strobes.hasRegByte = 1'b0;
    strobes.hasConst   = 1'b0;
    instrValid         = 1'b1;
    unique case (icode)
      IC_CMOV, IC_OP, IC_PUSH, IC_POP: strobes.hasRegByte = 1'b1;
      IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
        strobes.hasRegByte = 1'b1;
        strobes.hasConst   = 1'b1;
      end
      IC_JUMP, IC_CALL: strobes.hasConst = 1'b1;
      IC_HALT, IC_NOP, IC_RET: ;
      default: instrValid = 1'b0;
    endcase
  end

  always_comb begin
    if (memErr)               stat = ST_ADR;
    else if (!instrValid)     stat = ST_INS;
    else if (icode == IC_HALT) stat = ST_HLT;
    else                      stat = ST_AOK;
  end
endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0]                    pc,
  input  logic [(2+WORD_W/BYTE_W)*BYTE_W-1:0]  memWindow,
  input  fetchStrobes_t                        strobes,
  output logic [3:0]                           rA,
  output logic [3:0]                           rB,
  output logic [WORD_W-1:0]                    valC,
  output logic [WORD_W-1:0]                    valP
);
  localparam int CONST_BYTES = WORD_W / BYTE_W;
  localparam int CONST_LEN   = CONST_BYTES;

  logic [BYTE_W-1:0] regByte;
  assign regByte = memWindow[BYTE_W +: BYTE_W];

  always_comb begin
    if (strobes.hasRegByte) begin
      rA = regByte[7:4];
      rB = regByte[3:0];
    end else begin
      rA = REG_NONE;
      rB = REG_NONE;
    end
  end

  for (genvar b = 0; b < CONST_BYTES; b++) begin : g_constByte
    assign valC[b*BYTE_W +: BYTE_W] = strobes.hasRegByte
        ? memWindow[(b+2)*BYTE_W +: BYTE_W]
        : memWindow[(b+1)*BYTE_W +: BYTE_W];
  end

  logic [WORD_W-1:0] instLen;
  always_comb begin
    instLen = WORD_W'(1);
    if (strobes.hasRegByte) instLen = instLen + WORD_W'(1);
    if (strobes.hasConst)   instLen = instLen + WORD_W'(CONST_LEN);
  end

  assign valP = pc + instLen;
endmodule

// File: rtl/fetch_split.sv
module fetch_split
  import fetch_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BYTE_W = 8,
  localparam int WIN_W = (2 + WORD_W/BYTE_W) * BYTE_W
) (
  input  logic [WORD_W-1:0] pc,
  input  logic [WIN_W-1:0]  memWindow,
  input  logic              memErr,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [3:0]        rA,
  output logic [3:0]        rB,
  output logic [WORD_W-1:0] valC,
  output logic [WORD_W-1:0] valP,
  output logic              instrValid,
  output logic [2:0]        stat
);
  fetchStrobes_t strobes;

  fetch_ctrl u_ctrl (
    .opByte    (memWindow[BYTE_W-1:0]),
    .memErr    (memErr),
    .icode     (icode),
    .ifun      (ifun),
    .instrValid(instrValid),
    .stat      (stat),
    .strobes   (strobes)
  );

  fetch_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
    .pc       (pc),
    .memWindow(memWindow),
    .strobes  (strobes),
    .rA       (rA),
    .rB       (rB),
    .valC     (valC),
    .valP     (valP)
  );
endmodule

// File: rtl/fetch_split_chk.sv
module fetch_split_chk #(
  parameter int WORD_W = 64,
  parameter int WIN_W  = 80
) (
  input logic [WORD_W-1:0] pc,
  input logic [WIN_W-1:0]  memWindow,
  input logic              memErr,
  input logic [3:0]        icode,
  input logic [3:0]        ifun,
  input logic [3:0]        rA,
  input logic [3:0]        rB,
  input logic [WORD_W-1:0] valC,
  input logic [WORD_W-1:0] valP,
  input logic              instrValid,
  input logic [2:0]        stat
);
  logic [WORD_W-1:0] stepLen;
  logic              known;
  assign stepLen = valP - pc;
  assign known   = !$isunknown({pc, memWindow, memErr});

  always_comb begin
    if (known) begin
      assert_len_legal_R4: assert (stepLen == 1 || stepLen == 2 ||
                                   stepLen == 9 || stepLen == 10)
        else $error("length %0d", stepLen);
      assert_err_nop_R6: assert (!memErr || (icode == 4'h1 && ifun == 4'h0 && stepLen == 1))
        else $error("error did not force no-op");
      assert_err_prio_R9: assert (!memErr || stat == 3'd3)
        else $error("error status lost");
      assert_noreg_R5: assert (!(stepLen == 1 || stepLen == 9) || (rA == 4'hF && rB == 4'hF))
        else $error("specifiers not cleared");
      assert_invalid_R7: assert (stat != 3'd4 || !instrValid)
        else $error("INS with valid flag");
      assert_opcode_R1: assert (memErr || icode == memWindow[7:4])
        else $error("opcode mismatch");
    end
  end
endmodule

bind fetch_split fetch_split_chk #(.WORD_W(WORD_W), .WIN_W(WIN_W)) u_chk (
  .pc(pc), .memWindow(memWindow), .memErr(memErr), .icode(icode), .ifun(ifun),
  .rA(rA), .rB(rB), .valC(valC), .valP(valP), .instrValid(instrValid), .stat(stat)
);

// File: tb/sim_fetch_split.sv
`timescale 1ns/1ps
module sim_fetch_split;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] pc = '0;
  logic [79:0] memWindow = '0;
  logic        memErr = 1'b0;
  logic [3:0]  icode, ifun, rA, rB;
  logic [63:0] valC, valP;
  logic        instrValid;
  logic [2:0]  stat;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fetch_split u0 (
    .pc(pc), .memWindow(memWindow), .memErr(memErr), .icode(icode), .ifun(ifun),
    .rA(rA), .rB(rB), .valC(valC), .valP(valP), .instrValid(instrValid), .stat(stat)
  );

  typedef struct {
    logic [3:0]  icode, ifun, rA, rB;
    logic [63:0] valC, valP;
    logic        valid;
    logic [2:0]  stat;
  } expItem_t;

  expItem_t expQ[$];

  function automatic expItem_t model(logic [63:0] p, logic [79:0] w, logic e);
    expItem_t x;
    logic reg1, cst;
    x.icode = e ? 4'h1 : w[7:4];
    x.ifun  = e ? 4'h0 : w[3:0];
    reg1 = x.icode inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
    cst  = x.icode inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
    x.valid = x.icode <= 4'hB;
    x.rA = reg1 ? w[15:12] : 4'hF;
    x.rB = reg1 ? w[11:8]  : 4'hF;
    x.valC = reg1 ? w[79:16] : w[71:8];
    x.valP = p + 64'd1 + (reg1 ? 64'd1 : 64'd0) + (cst ? 64'd8 : 64'd0);
    if (e)             x.stat = 3'd3;
    else if (!x.valid) x.stat = 3'd4;
    else if (x.icode == 4'h0) x.stat = 3'd2;
    else               x.stat = 3'd1;
    return x;
  endfunction

  task automatic drive(input logic [63:0] p, input logic [79:0] w, input logic e);
    @(posedge clk);
    pc = p; memWindow = w; memErr = e;
    expQ.push_back(model(p, w, e));
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (pc=%h)", tag, act, exp, pc);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      chk("R1/R6 icode", 64'(icode), 64'(e.icode));
      chk("R1/R6 ifun",  64'(ifun),  64'(e.ifun));
      chk("R2/R5 rA",    64'(rA),    64'(e.rA));
      chk("R2/R5 rB",    64'(rB),    64'(e.rB));
      chk("R3 valC",     valC,       e.valC);
      chk("R4/R10 valP", valP,       e.valP);
      chk("R7 instrValid", 64'(instrValid), 64'(e.valid));
      chk("R8/R9 stat",  64'(stat),  64'(e.stat));
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [79:0] fill;
    fill = 80'h0123_4567_89AB_CDEF_55AA;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero window decodes as halt
    drive(64'h0, 80'h0, 1'b0);
    // R1..R8: every opcode nibble with varied bytes
    for (int op = 0; op < 16; op++) begin
      fill = {fill[78:0], fill[79] ^ fill[61] ^ fill[2]};
      drive(64'h1000 + 64'(op * 16), {fill[79:8], 4'(op), 4'(op ^ 5)}, 1'b0);
    end
    // R3: distinct constant bytes for jump and irmov alignment
    drive(64'h40, 80'h1122_3344_5566_7788_9970, 1'b0);
    drive(64'h40, 80'h1122_3344_5566_7788_3C30, 1'b0);
    // R6 R9: error overrides halt, undefined and normal bytes
    drive(64'h200, 80'h0, 1'b1);
    drive(64'h200, 80'hFFFF_FFFF_FFFF_FFFF_FFF3, 1'b1);
    drive(64'h200, 80'h1234_5678_9ABC_DEF0_1E6C, 1'b1);
    // R10: wrap around the top of the address space
    drive(64'hFFFF_FFFF_FFFF_FFFA, 80'hAAAA_BBBB_CCCC_DDDD_0130, 1'b0);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 80'h0000_0000_0000_0000_2360, 1'b0);
    drive(64'hFFFF_FFFF_FFFF_FFF8, 80'h0F0E_0D0C_0B0A_0908_0780, 1'b0);
    @(posedge clk);
    @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule